// File: doc/BRIEF.md
# Byte-Sync Block Transmitter

This block frames the transmit side of a byte-oriented synchronous line protocol. It walks a ring of buffer descriptors. Each descriptor has a ready flag, a byte count, and per-buffer attributes: end of message, wrap to the first slot, include in the check, restart the check, append the check, and interrupt. The block reads each buffer byte by byte through a simple offset/data read port. It hands characters one per handshake to a downstream serializer over a valid/ready pair. The serializer, the clocking and the memory behind the read port belong to the surrounding design.

While no buffer is pending, the line carries filler: either sync-character pairs or idle characters, chosen by a configuration bit. A message always opens with a full sync pair. The buffers of one message follow each other without filler. A block check, either a 16-bit CRC or an 8-bit sum, may close the message.

In transparent mode every data byte equal to the escape character is doubled on the line, and the check sees it only once. If a message runs out of ready buffers before its end, the block drops it, raises an underrun pulse and returns to filler. In transparent mode that filler is escape/sync pairs. Each finished buffer produces a completion pulse that carries the descriptor index. An interrupt pulse goes with it when that buffer asks for one.

Top module: `bsync_tx`

## Requirements
- R1: With `cfg_en` high and no frame in progress, the output repeats filler pairs: `cfg_syn1`,`cfg_syn2` when `cfg_idle`=0, or two idle characters 0xFF when `cfg_idle`=1. `d_ready` of the current descriptor is examined only when the second character of a filler pair is accepted.
- R2: Once a ready descriptor is seen at a pair boundary, the next characters are one complete `cfg_syn1`,`cfg_syn2` pair, followed by byte 0 of that buffer.
- R3: Buffer bytes leave in rising offset order from `rd_off`=0 to `d_len`-1 (`d_len` is at least 1). A buffer without the message-end flag is followed, after exactly one cycle with `tx_valid` low, by the next ready buffer with no sync characters.
- R4: After a buffer with both `d_last` and `d_tbcs` set, the block check follows. With `cfg_lrc`=0 it is the CRC of polynomial x^16+x^15+x^2+1, processed least significant bit first (reflected constant 0xA001), preset to zero, sent low byte first. With `cfg_lrc`=1 it is a single byte holding the sum of the checked bytes modulo 256.
- R5: A buffer with `d_last` set and `d_tbcs` clear ends the message with no check bytes, and filler resumes at the first character of a pair.
- R6: Only bytes of buffers with `d_incl` set enter the check. The check is cleared to zero at the start of every message and before the first byte of any later buffer with `d_rstbcs` set.
- R7: With `cfg_transp`=1, a data byte equal to 0x10 is sent twice in a row, and only one copy enters the check.
- R8: When a buffer without `d_last` ends and the next descriptor is not ready, `underrun` pulses for one cycle and the message is abandoned. Filler resumes: escape/sync pairs (0x10,`cfg_syn1`) if `cfg_transp` was set, else the R1 filler. The escape/sync filler lasts until the next message starts.
- R9: `done` pulses for one cycle, in the cycle after the last character of a buffer (including its check bytes) is accepted, with `done_idx` giving that descriptor. `irq` pulses in the same cycle exactly when that buffer's `d_intr` is set.
- R10: `desc_idx` changes only when a buffer completes. It then moves to the next slot, or to slot 0 after a descriptor with `d_wrap` set or after slot DEPTH-1.
- R11: Once `tx_valid` is high it stays high until the character is accepted, unless `cfg_en` falls. While `cfg_en` is low, `tx_valid` is low and the block returns to the start of a filler pair.
- R12: After reset `desc_idx` is 0 and `done`, `irq` and `underrun` are low, and the first character offered after enabling is the first character of a filler pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Transmitter enable |
| cfg_idle | input | 1 | Filler is idle characters instead of sync pairs |
| cfg_transp | input | 1 | Transparent mode (escape doubling) |
| cfg_lrc | input | 1 | Check is 8-bit sum instead of CRC16 |
| cfg_syn1 | input | 8 | First sync character |
| cfg_syn2 | input | 8 | Second sync character |
| desc_idx | output | IW | Descriptor slot being examined or sent |
| d_ready | input | 1 | Descriptor at `desc_idx` holds a buffer to send |
| d_last | input | 1 | Buffer ends the message |
| d_wrap | input | 1 | Next slot after this one is slot 0 |
| d_incl | input | 1 | Buffer bytes enter the check |
| d_rstbcs | input | 1 | Clear the check before this buffer |
| d_tbcs | input | 1 | Append the check after this message-end buffer |
| d_intr | input | 1 | Raise `irq` when this buffer completes |
| d_len | input | LW | Byte count of the buffer (at least 1) |
| rd_off | output | LW | Byte offset read within the current buffer |
| rd_byte | input | 8 | Byte at `rd_off` of buffer `desc_idx` |
| tx_data | output | 8 | Character offered to the serializer |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Serializer accepts the character this cycle |
| done | output | 1 | One-cycle buffer completion pulse |
| done_idx | output | IW | Slot of the completed buffer |
| irq | output | 1 | One-cycle interrupt pulse |
| underrun | output | 1 | One-cycle pulse when a message is abandoned |

## Verification
Characters leave on the rising edge where `tx_valid` and `tx_ready` are both high. `done`, `irq` and `underrun` follow in the next cycle, and a one-cycle gap with `tx_valid` low separates back-to-back buffers. The bench raises `tx_ready` for one handshake at a time and decides from `tx_valid` before the edge whether a character will leave. Its monitor samples all outputs shortly after the falling edge, before the next rising edge, and compares them against queues of expected characters and completion events. Descriptors are changed only while the output is stalled at a pair boundary. This makes the expected character sequence, including the pair-boundary start rule and the gap cycles, fixed by the requirements alone.

// File: rtl/bsync_pkg.sv
package bsync_pkg;

    localparam logic [7:0] ESC_CHAR  = 8'h10;
    localparam logic [7:0] IDLE_CHAR = 8'hFF;
    localparam logic [15:0] CRC_POLY_REFL = 16'hA001;

    typedef enum logic [2:0] {
        ST_FILL,
        ST_SYNA,
        ST_SYNB,
        ST_DATA,
        ST_NEXT,
        ST_CHK0,
        ST_CHK1
    } tx_state_e;

    typedef struct packed {
        logic last;
        logic wrap;
        logic incl;
        logic tbcs;
        logic intr;
    } buf_attr_t;

    function automatic logic [15:0] crc16_byte(input logic [15:0] cin, input logic [7:0] b);
        logic [15:0] r;
        r = cin;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/bsync_bcs.sv
module bsync_bcs
    import bsync_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [15:0] crc,
    output logic [7:0]  sum
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc <= '0;
            sum <= '0;
        end else if (upd) begin
            crc <= crc16_byte(crc, din);
            sum <= sum + din;
        end
    end
endmodule

// File: rtl/bsync_ring.sv
module bsync_ring #(
    parameter int DEPTH = 4,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          wrap,
    output logic [IW-1:0] idx
);
    localparam logic [IW-1:0] LAST_SLOT = IW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst)
            idx <= '0;
        else if (step)
            idx <= (wrap || idx == LAST_SLOT) ? '0 : idx + 1'b1;
    end
endmodule

// File: rtl/bsync_tx.sv
module bsync_tx
    import bsync_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LW    = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_en,
    input  logic          cfg_idle,
    input  logic          cfg_transp,
    input  logic          cfg_lrc,
    input  logic [7:0]    cfg_syn1,
    input  logic [7:0]    cfg_syn2,
    output logic [IW-1:0] desc_idx,
    input  logic          d_ready,
    input  logic          d_last,
    input  logic          d_wrap,
    input  logic          d_incl,
    input  logic          d_rstbcs,
    input  logic          d_tbcs,
    input  logic          d_intr,
    input  logic [LW-1:0] d_len,
    output logic [LW-1:0] rd_off,
    input  logic [7:0]    rd_byte,
    output logic [7:0]    tx_data,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic          done,
    output logic [IW-1:0] done_idx,
    output logic          irq,
    output logic          underrun
);
    tx_state_e     state, state_n;
    logic          phase, phase_n;
    logic          ufill, ufill_n;
    logic          stuffed, stuffed_n;
    logic [LW-1:0] off, off_n;
    logic [LW-1:0] len_q;
    buf_attr_t     attr;
    logic          load, bcs_clr, bcs_upd, fin, und;
    logic [15:0]   crc_v;
    logic [7:0]    sum_v;

    wire adv       = tx_valid && tx_ready;
    wire stuff_now = cfg_transp && (rd_byte == ESC_CHAR) && !stuffed;
    wire buf_end   = (off == len_q - LW'(1));

    always_comb begin
        state_n = state;  phase_n = phase;  ufill_n = ufill;
        stuffed_n = stuffed;  off_n = off;
        load = 1'b0;  bcs_clr = 1'b0;  bcs_upd = 1'b0;  fin = 1'b0;  und = 1'b0;
        if (!cfg_en) begin
            state_n = ST_FILL;  phase_n = 1'b0;  ufill_n = 1'b0;  stuffed_n = 1'b0;
        end else begin
            unique case (state)
                ST_FILL: if (adv) begin
                    phase_n = ~phase;
                    if (phase && d_ready) begin
                        state_n = ST_SYNA;
                        ufill_n = 1'b0;
                    end
                end
                ST_SYNA: if (adv) state_n = ST_SYNB;
                ST_SYNB: if (adv) begin
                    state_n = ST_DATA;  load = 1'b1;  bcs_clr = 1'b1;  off_n = '0;
                end
                ST_DATA: if (adv) begin
                    if (stuff_now) begin
                        stuffed_n = 1'b1;
                    end else begin
                        stuffed_n = 1'b0;
                        bcs_upd = attr.incl;
                        if (buf_end) begin
                            if (attr.last && attr.tbcs) begin
                                state_n = ST_CHK0;
                            end else begin
                                fin = 1'b1;  phase_n = 1'b0;
                                state_n = attr.last ? ST_FILL : ST_NEXT;
                            end
                        end else begin
                            off_n = off + LW'(1);
                        end
                    end
                end
                ST_NEXT: begin
                    if (d_ready) begin
                        state_n = ST_DATA;  load = 1'b1;  bcs_clr = d_rstbcs;  off_n = '0;
                    end else begin
                        und = 1'b1;  state_n = ST_FILL;  phase_n = 1'b0;  ufill_n = cfg_transp;
                    end
                end
                ST_CHK0: if (adv) begin
                    if (cfg_lrc) begin
                        fin = 1'b1;  state_n = ST_FILL;  phase_n = 1'b0;
                    end else begin
                        state_n = ST_CHK1;
                    end
                end
                ST_CHK1: if (adv) begin
                    fin = 1'b1;  state_n = ST_FILL;  phase_n = 1'b0;
                end
                default: state_n = ST_FILL;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FILL;  phase <= 1'b0;  ufill <= 1'b0;  stuffed <= 1'b0;
            off <= '0;  len_q <= '0;  attr <= '0;
            done <= 1'b0;  done_idx <= '0;  irq <= 1'b0;  underrun <= 1'b0;
        end else begin
            state <= state_n;  phase <= phase_n;  ufill <= ufill_n;
            stuffed <= stuffed_n;  off <= off_n;
            if (load) begin
                attr  <= '{last: d_last, wrap: d_wrap, incl: d_incl, tbcs: d_tbcs, intr: d_intr};
                len_q <= d_len;
            end
            done     <= fin;
            done_idx <= desc_idx;
            irq      <= fin && attr.intr;
            underrun <= und;
        end
    end

    always_comb begin
        unique case (state)
            ST_FILL: begin
                if (ufill)         tx_data = phase ? cfg_syn1 : ESC_CHAR;
                else if (cfg_idle) tx_data = IDLE_CHAR;
                else               tx_data = phase ? cfg_syn2 : cfg_syn1;
            end
            ST_SYNA: tx_data = cfg_syn1;
            ST_SYNB: tx_data = cfg_syn2;
            ST_DATA: tx_data = stuff_now ? ESC_CHAR : rd_byte;
            ST_CHK0: tx_data = cfg_lrc ? sum_v : crc_v[7:0];
            ST_CHK1: tx_data = crc_v[15:8];
            default: tx_data = IDLE_CHAR;
        endcase
    end

    assign tx_valid = cfg_en && (state != ST_NEXT);
    assign rd_off   = off;

    bsync_bcs u_bcs (
        .clk(clk), .rst(rst), .clr(bcs_clr), .upd(bcs_upd),
        .din(rd_byte), .crc(crc_v), .sum(sum_v)
    );

    bsync_ring #(.DEPTH(DEPTH)) u_ring (
        .clk(clk), .rst(rst), .step(fin), .wrap(attr.wrap), .idx(desc_idx)
    );
endmodule

// File: rtl/bsync_tx_chk.sv
module bsync_tx_chk #(
    parameter int DEPTH = 4,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_en,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic          done,
    input logic          irq,
    input logic          underrun,
    input logic [IW-1:0] desc_idx
);
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && tx_valid && !tx_ready) |=> (tx_valid || !cfg_en)); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        irq |-> done); // R9

    AST_UNDERRUN_ALONE: assert property (@(posedge clk) disable iff (rst)
        underrun |-> !done); // R8

    AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (rst)
        underrun |=> !underrun); // R8

    AST_IDX_MOVES_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        (desc_idx != $past(desc_idx)) |-> done); // R10
endmodule

bind bsync_tx bsync_tx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .done(done), .irq(irq), .underrun(underrun), .desc_idx(desc_idx)
);

// File: tb/bsync_tx_test.sv
module bsync_tx_test;
    localparam int CLK_T = 10;
    localparam int DEPTH = 4;
    localparam int LW    = 8;
    localparam int IW    = 2;
    localparam logic [7:0] S1 = 8'h32;
    localparam logic [7:0] S2 = 8'h16;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_en = 0, cfg_idle = 0, cfg_transp = 0, cfg_lrc = 0;
    logic [IW-1:0] desc_idx, done_idx;
    logic d_ready, d_last, d_wrap, d_incl, d_rstbcs, d_tbcs, d_intr;
    logic [LW-1:0] d_len, rd_off;
    logic [7:0] rd_byte, tx_data;
    logic tx_valid, tx_ready = 1'b0, done, irq, underrun;

    logic b_rdy[DEPTH], b_last[DEPTH], b_wrap[DEPTH], b_incl[DEPTH];
    logic b_rst[DEPTH], b_tbcs[DEPTH], b_intr[DEPTH];
    logic [LW-1:0] b_len[DEPTH];
    logic [7:0] b_mem[DEPTH][16];

    int nchk = 0, nbad = 0, und_seen = 0;
    logic [7:0] exp_q[$];
    string req_q[$];
    int done_q[$];

    always #(CLK_T/2) clk = ~clk;

    assign d_ready  = b_rdy[desc_idx];
    assign d_last   = b_last[desc_idx];
    assign d_wrap   = b_wrap[desc_idx];
    assign d_incl   = b_incl[desc_idx];
    assign d_rstbcs = b_rst[desc_idx];
    assign d_tbcs   = b_tbcs[desc_idx];
    assign d_intr   = b_intr[desc_idx];
    assign d_len    = b_len[desc_idx];
    assign rd_byte  = b_mem[desc_idx][rd_off[3:0]];

    bsync_tx #(.DEPTH(DEPTH), .LW(LW)) uut (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_idle(cfg_idle),
        .cfg_transp(cfg_transp), .cfg_lrc(cfg_lrc), .cfg_syn1(S1), .cfg_syn2(S2),
        .desc_idx(desc_idx), .d_ready(d_ready), .d_last(d_last), .d_wrap(d_wrap),
        .d_incl(d_incl), .d_rstbcs(d_rstbcs), .d_tbcs(d_tbcs), .d_intr(d_intr),
        .d_len(d_len), .rd_off(rd_off), .rd_byte(rd_byte), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .done(done), .done_idx(done_idx),
        .irq(irq), .underrun(underrun)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic expb(input logic [7:0] b, input string req);
        exp_q.push_back(b);
        req_q.push_back(req);
    endtask

    task automatic expd(input int idx, input bit ir);
        done_q.push_back({ir, 8'(idx)});
    endtask

    function automatic logic [15:0] ref_crc(input logic [7:0] q[$]);
        logic [15:0] c;
        logic fb;
        c = '0;
        foreach (q[k]) begin
            for (int j = 0; j < 8; j++) begin
                fb = c[0] ^ q[k][j];
                c = c >> 1;
                if (fb) c = c ^ 16'hA001;
            end
        end
        return c;
    endfunction

    task automatic setbuf(input int i, input logic [7:0] bytes[$], input bit last,
                          input bit wrap, input bit incl, input bit rs, input bit tb, input bit it);
        foreach (bytes[k]) b_mem[i][k] = bytes[k];
        b_len[i] = LW'(bytes.size());
        b_last[i] = last; b_wrap[i] = wrap; b_incl[i] = incl;
        b_rst[i] = rs; b_tbcs[i] = tb; b_intr[i] = it;
        b_rdy[i] = 1'b1;
    endtask

    task automatic pull(input int n);
        int got;
        got = 0;
        while (got < n) begin
            @(negedge clk);
            tx_ready = 1'b1;
            #2;
            if (tx_valid) got++;
            @(posedge clk);
        end
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    endtask

    always @(negedge clk) begin
        if (done) b_rdy[done_idx] = 1'b0;
    end

    always begin
        logic [7:0] e;
        string r;
        int d;
        @(negedge clk);
        #3;
        if (!rst) begin
            if (tx_valid && tx_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected character", tx_data, 0);
                end else begin
                    e = exp_q.pop_front();
                    r = req_q.pop_front();
                    check(tx_data == e, r, tx_data, e);
                end
            end
            if (done) begin
                if (done_q.size() == 0) begin
                    check(1'b0, "R9 unexpected done", {irq, 8'(done_idx)}, 0);
                end else begin
                    d = done_q.pop_front();
                    check({irq, 8'(done_idx)} == d[8:0], "R9 done/irq/index", {irq, 8'(done_idx)}, d[8:0]);
                end
            end
            if (underrun) und_seen++;
        end
    end

    initial begin
        #(CLK_T * 100000);
        nchk++;
        nbad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        logic [7:0] q[$];
        logic [15:0] c;
        for (int i = 0; i < DEPTH; i++) begin
            b_rdy[i] = 0; b_last[i] = 0; b_wrap[i] = 0; b_incl[i] = 0;
            b_rst[i] = 0; b_tbcs[i] = 0; b_intr[i] = 0; b_len[i] = '0;
            for (int k = 0; k < 16; k++) b_mem[i][k] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #3;
        check(tx_valid == 0, "R12 valid low while disabled", tx_valid, 0);
        check(desc_idx == 0, "R12 index after reset", desc_idx, 0);
        check({done, irq, underrun} == 3'b000, "R12 pulses low after reset", {done, irq, underrun}, 0);

        // R1 sync filler, R12 first character of a pair
        @(negedge clk);
        cfg_en = 1'b1;
        expb(S1, "R12"); expb(S2, "R1"); expb(S1, "R1"); expb(S2, "R1");
        pull(4);
        repeat (3) begin
            @(negedge clk); #3;
            check(tx_valid == 1 && tx_data == S1, "R11 held while stalled", tx_data, S1);
        end

        // R1 idle filler
        cfg_idle = 1'b1;
        expb(8'hFF, "R1"); expb(8'hFF, "R1");
        pull(2);
        cfg_idle = 1'b0;

        // R2 R3 R4 single-buffer message with CRC
        q = '{8'h41, 8'h42, 8'h43};
        setbuf(0, q, 1, 0, 1, 0, 1, 1);
        c = ref_crc(q);
        expb(S1, "R1"); expb(S2, "R1"); expb(S1, "R2"); expb(S2, "R2");
        foreach (q[k]) expb(q[k], "R3");
        expb(c[7:0], "R4 crc low"); expb(c[15:8], "R4 crc high");
        expd(0, 1);
        pull(9);
        expb(S1, "R2 filler after check"); expb(S2, "R2 filler after check");
        pull(2);

        // R6 exclusion, R4 sum check, R10 slot advance and wrap at end
        cfg_lrc = 1'b1;
        setbuf(1, '{8'h01, 8'h02}, 0, 0, 1, 0, 0, 1);
        setbuf(2, '{8'h05}, 0, 0, 0, 0, 0, 0);
        setbuf(3, '{8'h07, 8'h08}, 1, 0, 1, 0, 1, 1);
        expb(S1, "R1"); expb(S2, "R1"); expb(S1, "R2"); expb(S2, "R2");
        expb(8'h01, "R3"); expb(8'h02, "R3"); expb(8'h05, "R3 back to back");
        expb(8'h07, "R3"); expb(8'h08, "R3");
        expb(8'h12, "R6 sum skips excluded buffer");
        expd(1, 1); expd(2, 0); expd(3, 1);
        pull(10);
        cfg_lrc = 1'b0;
        repeat (2) @(negedge clk);
        #3;
        check(desc_idx == 0, "R10 wrap after last slot", desc_idx, 0);

        // R7 escape doubling, R8 underrun with escape/sync filler
        @(negedge clk);
        cfg_transp = 1'b1;
        setbuf(0, '{8'h10, 8'h55}, 0, 0, 1, 0, 0, 1);
        expb(S1, "R1"); expb(S2, "R1"); expb(S1, "R2"); expb(S2, "R2");
        expb(8'h10, "R7 inserted escape"); expb(8'h10, "R7 data escape"); expb(8'h55, "R7");
        expb(8'h10, "R8"); expb(S1, "R8"); expb(8'h10, "R8"); expb(S1, "R8");
        expd(0, 1);
        pull(11);
        check(und_seen == 1, "R8 underrun pulse", und_seen, 1);

        // R6 reset of check, R7 single escape in CRC, R10 wrap flag
        setbuf(1, '{8'hAA}, 0, 0, 1, 0, 0, 0);
        q = '{8'h10, 8'h33};
        setbuf(2, q, 1, 1, 1, 1, 1, 1);
        c = ref_crc(q);
        expb(8'h10, "R8"); expb(S1, "R8"); expb(S1, "R2"); expb(S2, "R2");
        expb(8'hAA, "R3"); expb(8'h10, "R7"); expb(8'h10, "R7"); expb(8'h33, "R7");
        expb(c[7:0], "R6 crc low after reset"); expb(c[15:8], "R6 crc high after reset");
        expd(1, 0); expd(2, 1);
        pull(10);
        expb(S1, "R8 escape filler ends"); expb(S2, "R8 escape filler ends");
        pull(2);
        check(desc_idx == 0, "R10 wrap flag", desc_idx, 0);
        cfg_transp = 1'b0;

        // R5 message end without check
        setbuf(0, '{8'hC3}, 1, 0, 1, 0, 0, 0);
        expb(S1, "R1"); expb(S2, "R1"); expb(S1, "R2"); expb(S2, "R2");
        expb(8'hC3, "R3"); expb(S1, "R5 no check bytes"); expb(S2, "R5 no check bytes");
        expd(0, 0);
        pull(7);
        check(desc_idx == 1, "R10 next slot", desc_idx, 1);

        // R11 disable
        @(negedge clk);
        cfg_en = 1'b0;
        #3;
        check(tx_valid == 0, "R11 disabled output", tx_valid, 0);
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R3 all characters seen", exp_q.size(), 0);
        check(done_q.size() == 0, "R9 all completions seen", done_q.size(), 0);
        check(und_seen == 1, "R8 single underrun overall", und_seen, 1);
        finish_run();
    end
endmodule